// File: doc/BRIEF.md
# Signal-Process Bytecode Execution Core

This block is a small multicycle processor that runs the body of one emulated hardware process. The process is written in a compact 32-bit bytecode. The bytecode mixes ordinary register arithmetic and local loads and stores with two instructions that move values between the register file and a shared table of signals. Each signal in that table has its own bit width.

A host drives the block through a narrow register port. The host loads instruction words and selects an entry word. It can also preset signal values and widths. It then requests a run. The core steps through fetch, decode, execute, memory and writeback, taking only the states each instruction needs. It stops when it retires a process-terminating instruction. It then drops `busy` and raises `done`, and the host can read the signal table and the local data memory back through the same port.

The controller is a single enumerated state machine with six states. `ST_IDLE` waits for a run request and moves to `ST_FETCH` when one is accepted. `ST_FETCH` always goes to `ST_DECODE`, and `ST_DECODE` always goes to `ST_EXEC`. From `ST_EXEC` the next state depends on the instruction:
- terminate goes to `ST_IDLE`;
- signal write and unknown opcodes go to `ST_FETCH`;
- store and load go to `ST_MEM`;
- add, add-immediate and signal read go to `ST_WB`.

From `ST_MEM`, a load goes to `ST_WB` and a store goes to `ST_FETCH`. `ST_WB` always returns to `ST_FETCH`.

Top module: `sproc_accel`

## Requirements
- R1: After reset, `busy` and `done` are 0 and the control word (host address 0) reads 0. Every signal width reads 32 (host address 6).
- R2: Writing host address 0 with bit 0 set while idle starts a run at the word held in host address 1. `busy` stays 1 until the terminate instruction (opcode 6'h3F) retires. `busy` then falls and `done` rises. The control word reads {err, done, busy} in bits 2..0.
- R3: Opcode 6'h01 writes rs+rt into rd. Opcode 6'h02 writes rs plus the sign-extended 16-bit immediate into rt. The fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and immediate [15:0].
- R4: Opcode 6'h03 stores rt to local data word (rs+imm)>>2. Opcode 6'h06 loads that word into rt. The host reads data word N by writing N to address 7 and reading address 8.
- R5: Opcode 6'h05 writes rt to signal [9:0], keeping only the signal's declared low bits. Opcode 6'h04 reads the signal into rt, zero-extended. Host writes to a signal value (address 5, selected by address 4) are also truncated, and widths are set at address 6.
- R6: A signal write takes effect at once, so a later signal read in the same run returns the new value.
- R7: Register 0 always reads 0, and writes to it are discarded.
- R8: A start request made while busy is ignored: the current run neither restarts nor changes entry.
- R9: A program word is written at address 3 into the slot held at address 2, which then increments. If this write comes while busy, it sets err and leaves the program and the slot unchanged. err clears on the next accepted start.
- R10: Busy cycles per instruction are 3 for signal write, terminate and unknown opcodes, 4 for add, add-immediate, signal read and store, and 5 for load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr`, combinational |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run retired its terminate instruction |

## Verification
The bench builds the core with its default parameters: 64 program words, 64 data words, 64 signals and 32 registers. That is enough room for a main program at word 0 and a second program at word 20, with signals of width 1, 4, 8 and 32 side by side. Data word 2 is reached both by a store with a non-zero base register and by a load with base register 0. A 61-cycle run measures the per-instruction cycle counts. Host start and load requests are issued in the middle of the second program's run.

// File: rtl/sproc_pkg.sv
package sproc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } st_e;

    localparam logic [5:0] OP_ADD   = 6'h01;
    localparam logic [5:0] OP_ADDI  = 6'h02;
    localparam logic [5:0] OP_SW    = 6'h03;
    localparam logic [5:0] OP_READ  = 6'h04;
    localparam logic [5:0] OP_WRITE = 6'h05;
    localparam logic [5:0] OP_LW    = 6'h06;
    localparam logic [5:0] OP_END   = 6'h3F;

    localparam logic [3:0] HA_CTRL  = 4'd0;
    localparam logic [3:0] HA_ENTRY = 4'd1;
    localparam logic [3:0] HA_PADDR = 4'd2;
    localparam logic [3:0] HA_PDATA = 4'd3;
    localparam logic [3:0] HA_SSEL  = 4'd4;
    localparam logic [3:0] HA_SDATA = 4'd5;
    localparam logic [3:0] HA_SWID  = 4'd6;
    localparam logic [3:0] HA_DADDR = 4'd7;
    localparam logic [3:0] HA_DDATA = 4'd8;

    function automatic logic [31:0] width_mask(input logic [5:0] w);
        if (w == 6'd0 || w >= 6'd32) return 32'hFFFF_FFFF;
        return (32'h1 << w) - 32'h1;
    endfunction

endpackage

// File: rtl/sproc_regfile.sv
module sproc_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [DW-1:0] rda,
    output logic [DW-1:0] rdb,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rda = (ra == '0) ? '0 : regs[ra];
    assign rdb = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/sproc_sigmem.sv
module sproc_sigmem import sproc_pkg::*; #(
    parameter int NSIG  = 64,
    localparam int IW   = $clog2(NSIG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] c_idx,
    input  logic          c_valid,
    output logic [31:0]   c_rdata,
    input  logic          c_we,
    input  logic [31:0]   c_wdata,
    input  logic [IW-1:0] h_idx,
    output logic [31:0]   h_rdata,
    output logic [5:0]    h_rwidth,
    input  logic          h_we_val,
    input  logic          h_we_wid,
    input  logic [31:0]   h_wdata
);
    logic [31:0] vals [NSIG];
    logic [5:0]  wids [NSIG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSIG; i++) begin
                vals[i] <= '0;
                wids[i] <= 6'd32;
            end
        end else if (c_we && c_valid) begin
            vals[c_idx] <= c_wdata & width_mask(wids[c_idx]);
        end else if (h_we_val) begin
            vals[h_idx] <= h_wdata & width_mask(wids[h_idx]);
        end else if (h_we_wid) begin
            wids[h_idx] <= h_wdata[5:0];
        end
    end

    assign c_rdata  = c_valid ? vals[c_idx] : '0;
    assign h_rdata  = vals[h_idx];
    assign h_rwidth = wids[h_idx];

    AST_SIG_TRUNCATED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && c_valid) |=> ((vals[$past(c_idx)] & ~width_mask(wids[$past(c_idx)])) == '0)); // R5

endmodule

// File: rtl/sproc_ctrl.sv
module sproc_ctrl import sproc_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic [5:0] op,
    output st_e        state,
    output logic       busy,
    output logic       done,
    output logic       launch,
    output logic       fetch_en,
    output logic       decode_en,
    output logic       exec_en,
    output logic       mem_en,
    output logic       wb_en
);
    st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (op)
                    OP_END:                    state_d = ST_IDLE;
                    OP_SW, OP_LW:              state_d = ST_MEM;
                    OP_ADD, OP_ADDI, OP_READ:  state_d = ST_WB;
                    default:                   state_d = ST_FETCH;
                endcase
            end
            ST_MEM:    state_d = (op == OP_LW) ? ST_WB : ST_FETCH;
            ST_WB:     state_d = ST_FETCH;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        launch    = (state_q == ST_IDLE) && start_req;
        fetch_en  = (state_q == ST_FETCH);
        decode_en = (state_q == ST_DECODE);
        exec_en   = (state_q == ST_EXEC);
        mem_en    = (state_q == ST_MEM);
        wb_en     = (state_q == ST_WB);
        busy      = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        done <= 1'b0;
        else if (launch)                   done <= 1'b0;
        else if (exec_en && op == OP_END)  done <= 1'b1;
    end

    assign state = state_q;

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == ST_EXEC && $past(op) == OP_END)); // R2
    AST_BUSY_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && state_q == ST_DECODE) |=> (state_q == ST_EXEC)); // R8

endmodule

// File: rtl/sproc_accel.sv
module sproc_accel import sproc_pkg::*; #(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    parameter int NSIG       = 64,
    parameter int NREG       = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        busy,
    output logic        done
);
    localparam int PC_W  = $clog2(IMEM_DEPTH);
    localparam int DA_W  = $clog2(DMEM_DEPTH);
    localparam int SIG_W = $clog2(NSIG);
    localparam int RA_W  = $clog2(NREG);

    logic [31:0]     imem [IMEM_DEPTH];
    logic [31:0]     dmem [DMEM_DEPTH];
    logic [PC_W-1:0] pc_q, entry_q, paddr_q;
    logic [SIG_W-1:0] ssel_q;
    logic [DA_W-1:0] daddr_q;
    logic            err_q;
    logic [31:0]     ir_q, a_q, b_q, alu_q, mdr_q;

    st_e  state;
    logic launch, fetch_en, decode_en, exec_en, mem_en, wb_en;
    logic start_req;

    logic [5:0]      op;
    logic [RA_W-1:0] f_rs, f_rt, f_rd;
    logic [31:0]     imm_sx;
    logic [9:0]      f_sig;
    logic            sig_valid;

    assign op      = ir_q[31:26];
    assign f_rs    = ir_q[21 +: RA_W];
    assign f_rt    = ir_q[16 +: RA_W];
    assign f_rd    = ir_q[11 +: RA_W];
    assign imm_sx  = {{16{ir_q[15]}}, ir_q[15:0]};
    assign f_sig   = ir_q[9:0];
    assign sig_valid = (f_sig < 10'(NSIG));

    assign start_req = host_wr && (host_addr == HA_CTRL) && host_wdata[0];

    sproc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .op        (op),
        .state     (state),
        .busy      (busy),
        .done      (done),
        .launch    (launch),
        .fetch_en  (fetch_en),
        .decode_en (decode_en),
        .exec_en   (exec_en),
        .mem_en    (mem_en),
        .wb_en     (wb_en)
    );

    logic [31:0]     rf_a, rf_b, rf_wd;
    logic [RA_W-1:0] rf_wa;
    logic            rf_we;

    assign rf_we = wb_en;
    assign rf_wa = (op == OP_ADD) ? f_rd : f_rt;
    assign rf_wd = (op == OP_LW) ? mdr_q : alu_q;

    sproc_regfile #(.NREG(NREG), .DW(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (f_rs),
        .rb    (f_rt),
        .rda   (rf_a),
        .rdb   (rf_b),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    logic [31:0] sig_c_rdata, sig_h_rdata;
    logic [5:0]  sig_h_width;
    logic        sig_c_we, sig_h_we_val, sig_h_we_wid;

    assign sig_c_we     = exec_en && (op == OP_WRITE);
    assign sig_h_we_val = host_wr && (host_addr == HA_SDATA) && !busy;
    assign sig_h_we_wid = host_wr && (host_addr == HA_SWID) && !busy;

    sproc_sigmem #(.NSIG(NSIG)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .c_idx    (f_sig[SIG_W-1:0]),
        .c_valid  (sig_valid),
        .c_rdata  (sig_c_rdata),
        .c_we     (sig_c_we),
        .c_wdata  (b_q),
        .h_idx    (ssel_q),
        .h_rdata  (sig_h_rdata),
        .h_rwidth (sig_h_width),
        .h_we_val (sig_h_we_val),
        .h_we_wid (sig_h_we_wid),
        .h_wdata  (host_wdata)
    );

    // Host-side registers and program loading
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
            paddr_q <= '0;
            ssel_q  <= '0;
            daddr_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (launch) err_q <= 1'b0;
            if (host_wr) begin
                unique case (host_addr)
                    HA_ENTRY: entry_q <= host_wdata[PC_W-1:0];
                    HA_PADDR: paddr_q <= host_wdata[PC_W-1:0];
                    HA_PDATA: begin
                        if (busy) err_q <= 1'b1;
                        else      paddr_q <= paddr_q + 1'b1;
                    end
                    HA_SSEL:  ssel_q  <= host_wdata[SIG_W-1:0];
                    HA_DADDR: daddr_q <= host_wdata[DA_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (host_wr && host_addr == HA_PDATA && !busy) imem[paddr_q] <= host_wdata;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
            mdr_q <= '0;
        end else begin
            if (launch) pc_q <= entry_q;
            if (fetch_en) begin
                ir_q <= imem[pc_q];
                pc_q <= pc_q + 1'b1;
            end
            if (decode_en) begin
                a_q <= rf_a;
                b_q <= rf_b;
            end
            if (exec_en) begin
                unique case (op)
                    OP_ADD:  alu_q <= a_q + b_q;
                    OP_READ: alu_q <= sig_c_rdata;
                    default: alu_q <= a_q + imm_sx;
                endcase
            end
            if (mem_en && op == OP_LW) mdr_q <= dmem[alu_q[2 +: DA_W]];
        end
    end

    always_ff @(posedge clk) begin
        if (mem_en && op == OP_SW) dmem[alu_q[2 +: DA_W]] <= b_q;
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            HA_CTRL:  host_rdata = {29'd0, err_q, done, busy};
            HA_ENTRY: host_rdata = 32'(entry_q);
            HA_PADDR: host_rdata = 32'(paddr_q);
            HA_SSEL:  host_rdata = 32'(ssel_q);
            HA_SDATA: host_rdata = sig_h_rdata;
            HA_SWID:  host_rdata = 32'(sig_h_width);
            HA_DADDR: host_rdata = 32'(daddr_q);
            HA_DDATA: host_rdata = dmem[daddr_q];
            default:  host_rdata = '0;
        endcase
    end

    AST_LOAD_WHILE_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == HA_PDATA && busy) |=> (err_q && $stable(paddr_q))); // R9
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_en && f_rs == '0) |=> (a_q == '0)); // R7
    AST_RUN_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (pc_q == $past(entry_q))); // R2
    AST_LOAD_FIVE_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && op == OP_LW) |=> wb_en); // R10

endmodule

// File: tb/sproc_accel_bench.sv
module sproc_accel_bench;
    import sproc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sproc_accel u_sproc_accel (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done)
    );

    // Scoreboard queues: expected signal contents
    int          sb_idx [$];
    logic [31:0] sb_val [$];
    string       sb_tag [$];

    function automatic logic [31:0] enc_r(logic [5:0] o, int rs, int rt, int rd);
        return {o, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] o, int rs, int rt, logic [15:0] im);
        return {o, 5'(rs), 5'(rt), im};
    endfunction
    function automatic logic [31:0] enc_s(logic [5:0] o, int rt, int idx);
        return {o, 5'd0, 5'(rt), 6'd0, 10'(idx)};
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic set_sig(input int idx, input int w, input logic [31:0] v);
        host_write(HA_SSEL, 32'(idx));
        host_write(HA_SWID, 32'(w));
        host_write(HA_SDATA, v);
    endtask

    task automatic expect_sig(input int idx, input logic [31:0] v, input string tag);
        sb_idx.push_back(idx);
        sb_val.push_back(v);
        sb_tag.push_back(tag);
    endtask

    task automatic drain_scoreboard();
        logic [31:0] got;
        while (sb_idx.size() > 0) begin
            int i;
            logic [31:0] e;
            string t;
            i = sb_idx.pop_front();
            e = sb_val.pop_front();
            t = sb_tag.pop_front();
            host_write(HA_SSEL, 32'(i));
            host_read(HA_SDATA, got);
            check(got, e, t);
        end
    endtask

    task automatic wait_done(input string tag);
        int guard = 0;
        while (!(done && !busy) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) check(32'(done), 32'd1, {tag, " run timeout"});
    endtask

    initial begin
        logic [31:0] rd;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_read(HA_CTRL, rd);
        check(rd, 32'd0, "R1 control word after reset");
        host_read(HA_SWID, rd);
        check(rd, 32'd32, "R1 default signal width");

        // Program A at word 0
        host_write(HA_PADDR, 32'd0);
        host_write(HA_PDATA, enc_i(OP_ADDI, 0, 1, 16'd5));
        host_write(HA_PDATA, enc_i(OP_ADDI, 0, 2, 16'hFFFD));
        host_write(HA_PDATA, enc_r(OP_ADD, 1, 2, 3));
        host_write(HA_PDATA, enc_s(OP_WRITE, 3, 0));
        host_write(HA_PDATA, enc_s(OP_WRITE, 2, 1));
        host_write(HA_PDATA, enc_s(OP_READ, 5, 1));
        host_write(HA_PDATA, enc_s(OP_WRITE, 5, 3));
        host_write(HA_PDATA, enc_i(OP_ADDI, 0, 6, 16'd4));
        host_write(HA_PDATA, enc_i(OP_SW, 6, 2, 16'd4));
        host_write(HA_PDATA, enc_i(OP_LW, 0, 7, 16'd8));
        host_write(HA_PDATA, enc_s(OP_WRITE, 7, 4));
        host_write(HA_PDATA, enc_i(OP_ADDI, 0, 0, 16'd9));
        host_write(HA_PDATA, enc_s(OP_WRITE, 0, 5));
        host_write(HA_PDATA, enc_s(OP_READ, 8, 7));
        host_write(HA_PDATA, enc_s(OP_WRITE, 8, 6));
        host_write(HA_PDATA, enc_s(OP_WRITE, 1, 2));
        host_write(HA_PDATA, {OP_END, 26'd0});

        // Program B at word 20
        host_write(HA_PADDR, 32'd20);
        host_write(HA_PDATA, enc_i(OP_ADDI, 0, 9, 16'h0077));
        host_write(HA_PDATA, enc_s(OP_WRITE, 9, 10));
        host_write(HA_PDATA, {OP_END, 26'd0});

        // Signal setup
        set_sig(1, 4, 32'd0);
        set_sig(2, 1, 32'd0);
        set_sig(5, 32, 32'h55);
        set_sig(7, 8, 32'hFFFF_FFFF);
        host_write(HA_SSEL, 32'd7);
        host_read(HA_SDATA, rd);
        check(rd, 32'hFF, "R5 host write truncated to 8 bits");

        // Run A, counting busy cycles
        host_write(HA_ENTRY, 32'd0);
        host_write(HA_CTRL, 32'd1);
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        check(32'(cyc), 32'd61, "R10 busy cycles for program A");
        host_read(HA_CTRL, rd);
        check(rd, 32'b010, "R2 done set and busy clear after terminate");

        expect_sig(0, 32'd2, "R3 add of 5 and -3");
        expect_sig(1, 32'hD, "R5 write truncated to 4 bits");
        expect_sig(3, 32'hD, "R6 read sees earlier write");
        expect_sig(4, 32'hFFFF_FFFD, "R4 load after store");
        expect_sig(5, 32'd0, "R7 register 0 stays zero");
        expect_sig(6, 32'hFF, "R5 read zero-extended");
        expect_sig(2, 32'd1, "R5 write truncated to 1 bit");
        drain_scoreboard();

        host_write(HA_DADDR, 32'd2);
        host_read(HA_DDATA, rd);
        check(rd, 32'hFFFF_FFFD, "R4 data word 2 from store");

        // Run B with host interference while busy
        set_sig(0, 32, 32'h1234);
        host_write(HA_PADDR, 32'd21);
        host_write(HA_ENTRY, 32'd20);
        host_write(HA_CTRL, 32'd1);
        host_write(HA_PDATA, enc_s(OP_WRITE, 9, 11));
        host_write(HA_ENTRY, 32'd0);
        host_write(HA_CTRL, 32'd1);
        wait_done("R8");
        host_read(HA_CTRL, rd);
        check(rd, 32'b110, "R9 err set by load while busy");
        host_read(HA_PADDR, rd);
        check(rd, 32'd21, "R9 slot not advanced");
        expect_sig(10, 32'h77, "R2 run from entry word 20");
        expect_sig(0, 32'h1234, "R8 start while busy ignored");
        expect_sig(11, 32'd0, "R9 program unchanged");
        drain_scoreboard();

        // Rerun B, err clears
        host_write(HA_ENTRY, 32'd20);
        host_write(HA_CTRL, 32'd1);
        host_read(HA_CTRL, rd);
        check(rd, 32'b001, "R9 err cleared on accepted start");
        wait_done("R9");
        expect_sig(11, 32'd0, "R9 rerun shows original program");
        expect_sig(10, 32'h77, "R2 rerun result");
        drain_scoreboard();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule